// File: doc/BRIEF.md
# Differential Clock Output Enable and Mode Controller

This block computes the final drive enables for twelve differential clock outputs, split into a group of ten and a group of two. Each output's enable combines an active-low enable pin with a register enable bit. The two-output group shares a single pin. A change to an enable takes effect only while that output's clock is low, so no shortened pulse reaches the output.

The block also merges strap pins with register bits to form the loop-bandwidth select and the fanout-bypass select. It passes out a gear-engage flag for each group. It captures the frequency-select strap while an active-low power-good input qualifies it. An active-high power-down request turns every output off at once, with no clock needed. After the request is released, the outputs stay off for a programmable number of reference cycles and then become eligible together.

Top module: `clk_oe_ctrl`

## Requirements
- R1: While `rstN` is 0, `driveEn` is all zero and `fsLatched` is 0.
- R2: Output n (n below 10) drives (`driveEn[n]`=1) only when pin `oeN[n]` is 0 and `regEn[n]` is 1; otherwise it is off (0, Hi-Z).
- R3: Outputs 10 and 11 both use pin `oeN[10]`, each qualified by its own bit `regEn[10]` / `regEn[11]`.
- R4: `hiBwSel` is 1 (high bandwidth) when `hiBwStrapN` is 0 or `hiBwRegN` is 0, else 0.
- R5: `bypassSel` is 1 (fanout bypass) when `bypStrapN` is 0 or `bypRegN` is 0; with both at 1 it is 0 (PLL mode).
- R6: `gearOnA` (group of ten) is 1 exactly when `ratioRegA` is 0, and `gearOnB` (group of two) is 1 exactly when `ratioRegB` is 0; a 1 in a ratio bit means 1:1.
- R7: On a clock edge where `pwrGdN` is 0, `fsLatched` takes `fsStrap`; on an edge where `pwrGdN` is 1 it holds.
- R8: While `pdReq` is 1, `driveEn` is all zero at once, with no clock edge needed.
- R9: After `pdReq` falls, `driveEn` stays zero through the first `wakeCount`+1 clock edges; at edge `wakeCount`+2 every eligible output turns on.
- R10: Outside power-down, `driveEn[n]` changes only at a clock edge where `outPhase[n]` (the level of output n's clock) is 0; it holds while `outPhase[n]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReq | input | 1 | Asynchronous active-high power-down request |
| pwrGdN | input | 1 | Active-low qualifier for capturing the frequency strap |
| fsStrap | input | 1 | Frequency-select strap |
| oeN | input | 11 | Active-low enable pins; bit 10 serves outputs 10 and 11 |
| regEn | input | 12 | Register enable bit per output, 1 = enable |
| outPhase | input | 12 | Current level of each output clock |
| wakeCount | input | 8 | Extra reference cycles of hold-off after power-down |
| hiBwStrapN | input | 1 | Bandwidth strap, 0 = high bandwidth |
| hiBwRegN | input | 1 | Bandwidth register bit, 0 = high bandwidth |
| bypStrapN | input | 1 | Bypass strap, 0 = fanout bypass, 1 = PLL |
| bypRegN | input | 1 | Bypass register bit, 0 = fanout bypass |
| ratioRegA | input | 1 | Ratio bit for the group of ten, 1 = 1:1 |
| ratioRegB | input | 1 | Ratio bit for the group of two, 1 = 1:1 |
| driveEn | output | 12 | Drive enable per output, 0 = Hi-Z |
| hiBwSel | output | 1 | High loop bandwidth selected |
| bypassSel | output | 1 | Fanout bypass selected |
| gearOnA | output | 1 | Gear ratio engaged for the group of ten |
| gearOnB | output | 1 | Gear ratio engaged for the group of two |
| fsLatched | output | 1 | Captured frequency strap |

## Verification
The assertions check on every cycle that power-down holds every output off, that no output turns on during the post-power-down hold-off, and that no output turns on at an edge where its clock was high. They also check that the strap capture follows the power-good qualifier and that the mode selects stay clear when both of their sources are 1. Only the bench's scenarios can show the exact edge on which outputs return after power-down for different hold-off counts. The same holds for the shared pin of the two-output group, and for an enable change that is held back and later applied once the output's clock goes low.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;
  // Strobes from the wake sequencer to the enable datapath
  typedef struct packed {
    logic asleep;    // hold-off after power-down still running
    logic forceOff;  // power-down request, combinational
  } wake_stb_t;
endpackage

// File: rtl/clk_oe_wake.sv
module clk_oe_wake #(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pdReq,
  input  logic [CNT_W-1:0]        wakeCount,
  output clk_oe_pkg::wake_stb_t   stb
);
  logic [CNT_W-1:0] wakeCnt;
  logic             asleep;

  // Power-down clears the counter and arms the hold-off
  always_ff @(posedge clk or negedge rstN or posedge pdReq) begin
    if (!rstN) begin
      wakeCnt <= '0;
      asleep  <= 1'b0;
    end else if (pdReq) begin
      wakeCnt <= '0;
      asleep  <= 1'b1;
    end else if (asleep) begin
      if (wakeCnt >= wakeCount) asleep <= 1'b0;
      else                      wakeCnt <= wakeCnt + 1'b1;
    end
  end

  always_comb begin
    stb.asleep   = asleep;
    stb.forceOff = pdReq;
  end
endmodule

// File: rtl/clk_oe_gate.sv
module clk_oe_gate #(
  parameter int GRP_A = 10,
  parameter int GRP_B = 2,
  localparam int NUM_OUT = GRP_A + GRP_B
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pdReq,
  input  clk_oe_pkg::wake_stb_t stb,
  input  logic                  pwrGdN,
  input  logic                  fsStrap,
  input  logic [GRP_A:0]        oeN,
  input  logic [NUM_OUT-1:0]    regEn,
  input  logic [NUM_OUT-1:0]    outPhase,
  input  logic                  hiBwStrapN,
  input  logic                  hiBwRegN,
  input  logic                  bypStrapN,
  input  logic                  bypRegN,
  input  logic                  ratioRegA,
  input  logic                  ratioRegB,
  output logic [NUM_OUT-1:0]    driveEn,
  output logic                  hiBwSel,
  output logic                  bypassSel,
  output logic                  gearOnA,
  output logic                  gearOnB,
  output logic                  fsLatched
);
  logic [NUM_OUT-1:0] wantEn;
  logic [NUM_OUT-1:0] driveReg;

  // Pin lookup: the second group shares the last pin
  for (genvar n = 0; n < NUM_OUT; n++) begin : g_want
    localparam int PIN = (n < GRP_A) ? n : GRP_A;
    assign wantEn[n] = ~oeN[PIN] & regEn[n];
  end

  // Enable changes land only while the output clock is low
  always_ff @(posedge clk or negedge rstN or posedge pdReq) begin
    if (!rstN || pdReq) begin
      driveReg <= '0;
    end else begin
      for (int n = 0; n < NUM_OUT; n++) begin
        if (!outPhase[n]) driveReg[n] <= wantEn[n] & ~stb.asleep;
      end
    end
  end

  assign driveEn = driveReg & {NUM_OUT{~stb.forceOff}};

  // Strap capture qualified by power-good
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        fsLatched <= 1'b0;
    else if (!pwrGdN) fsLatched <= fsStrap;
  end

  // Any zero from strap or register selects the mode
  assign hiBwSel   = ~(hiBwStrapN & hiBwRegN);
  assign bypassSel = ~(bypStrapN & bypRegN);
  assign gearOnA   = ~ratioRegA;
  assign gearOnB   = ~ratioRegB;
endmodule

// File: rtl/clk_oe_ctrl.sv
module clk_oe_ctrl #(
  parameter int GRP_A = 10,
  parameter int GRP_B = 2,
  parameter int CNT_W = 8,
  localparam int NUM_OUT = GRP_A + GRP_B
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdReq,
  input  logic               pwrGdN,
  input  logic               fsStrap,
  input  logic [GRP_A:0]     oeN,
  input  logic [NUM_OUT-1:0] regEn,
  input  logic [NUM_OUT-1:0] outPhase,
  input  logic [CNT_W-1:0]   wakeCount,
  input  logic               hiBwStrapN,
  input  logic               hiBwRegN,
  input  logic               bypStrapN,
  input  logic               bypRegN,
  input  logic               ratioRegA,
  input  logic               ratioRegB,
  output logic [NUM_OUT-1:0] driveEn,
  output logic               hiBwSel,
  output logic               bypassSel,
  output logic               gearOnA,
  output logic               gearOnB,
  output logic               fsLatched
);
  clk_oe_pkg::wake_stb_t stb;

  clk_oe_wake #(.CNT_W(CNT_W)) u_wake (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .wakeCount(wakeCount), .stb(stb)
  );

  clk_oe_gate #(.GRP_A(GRP_A), .GRP_B(GRP_B)) u_gate (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .stb(stb),
    .pwrGdN(pwrGdN), .fsStrap(fsStrap), .oeN(oeN), .regEn(regEn),
    .outPhase(outPhase), .hiBwStrapN(hiBwStrapN), .hiBwRegN(hiBwRegN),
    .bypStrapN(bypStrapN), .bypRegN(bypRegN), .ratioRegA(ratioRegA),
    .ratioRegB(ratioRegB), .driveEn(driveEn), .hiBwSel(hiBwSel),
    .bypassSel(bypassSel), .gearOnA(gearOnA), .gearOnB(gearOnB),
    .fsLatched(fsLatched)
  );
endmodule

// File: rtl/clk_oe_chk.sv
module clk_oe_chk #(
  parameter int NUM_OUT = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  pdReq,
  input logic                  pwrGdN,
  input logic                  fsStrap,
  input logic [NUM_OUT-1:0]    outPhase,
  input logic                  hiBwStrapN,
  input logic                  hiBwRegN,
  input logic                  bypStrapN,
  input logic                  bypRegN,
  input clk_oe_pkg::wake_stb_t stb,
  input logic [NUM_OUT-1:0]    driveEn,
  input logic                  hiBwSel,
  input logic                  bypassSel,
  input logic                  fsLatched
);
  // R8
  pd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdReq |-> (driveEn == '0));

  // R9
  holdoff_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.asleep |-> (driveEn == '0));

  // R7
  fs_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGdN |=> (fsLatched == $past(fsStrap)));

  // R7
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrGdN |=> $stable(fsLatched));

  // R4
  bw_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hiBwStrapN && hiBwRegN) |-> !hiBwSel);

  // R5
  pll_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bypStrapN && bypRegN) |-> !bypassSel);

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    // R10
    clean_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(driveEn[n]) |-> !$past(outPhase[n]));
  end
endmodule

bind clk_oe_ctrl clk_oe_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .pdReq(pdReq), .pwrGdN(pwrGdN), .fsStrap(fsStrap),
  .outPhase(outPhase), .hiBwStrapN(hiBwStrapN), .hiBwRegN(hiBwRegN),
  .bypStrapN(bypStrapN), .bypRegN(bypRegN), .stb(stb), .driveEn(driveEn),
  .hiBwSel(hiBwSel), .bypassSel(bypassSel), .fsLatched(fsLatched)
);

// File: tb/clk_oe_ctrl_bench.sv
`timescale 1ns/1ps
module clk_oe_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN, pdReq, pwrGdN, fsStrap;
  logic [10:0] oeN;
  logic [11:0] regEn, outPhase, driveEn;
  logic [7:0]  wakeCount;
  logic        hiBwStrapN, hiBwRegN, bypStrapN, bypRegN, ratioRegA, ratioRegB;
  logic        hiBwSel, bypassSel, gearOnA, gearOnB, fsLatched;
  int          nChk = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  clk_oe_ctrl u_clk_oe_ctrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .pwrGdN(pwrGdN), .fsStrap(fsStrap),
    .oeN(oeN), .regEn(regEn), .outPhase(outPhase), .wakeCount(wakeCount),
    .hiBwStrapN(hiBwStrapN), .hiBwRegN(hiBwRegN), .bypStrapN(bypStrapN),
    .bypRegN(bypRegN), .ratioRegA(ratioRegA), .ratioRegB(ratioRegB),
    .driveEn(driveEn), .hiBwSel(hiBwSel), .bypassSel(bypassSel),
    .gearOnA(gearOnA), .gearOnB(gearOnB), .fsLatched(fsLatched)
  );

  // {hiStrapN, hiRegN, bypStrapN, bypRegN, ratioA, ratioB, expHi, expByp, expGearA, expGearB}
  localparam logic [9:0] MODE_VEC [8] = '{
    10'b1111_11_0000, 10'b0111_10_1001, 10'b1011_01_1010, 10'b1101_00_0111,
    10'b1110_11_0100, 10'b0000_11_1100, 10'b0101_01_1110, 10'b1010_10_1101
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 0; pdReq = 0; pwrGdN = 1; fsStrap = 0;
    oeN = '1; regEn = '1; outPhase = '0; wakeCount = 8'd3;
    hiBwStrapN = 1; hiBwRegN = 1; bypStrapN = 1; bypRegN = 1;
    ratioRegA = 1; ratioRegB = 1;
    repeat (3) step();
    chk("R1 driveEn in reset", 32'(driveEn), 32'h0);
    chk("R1 fsLatched in reset", 32'(fsLatched), 32'h0);
    rstN = 1;
    step();
    chk("R2 pins high keep outputs off", 32'(driveEn), 32'h0);

    // R4 R5 R6 mode-select table
    for (int i = 0; i < 8; i++) begin
      {hiBwStrapN, hiBwRegN, bypStrapN, bypRegN, ratioRegA, ratioRegB} = MODE_VEC[i][9:4];
      #1;
      chk($sformatf("R4 hiBwSel vec %0d", i), 32'(hiBwSel), 32'(MODE_VEC[i][3]));
      chk($sformatf("R5 bypassSel vec %0d", i), 32'(bypassSel), 32'(MODE_VEC[i][2]));
      chk($sformatf("R6 gear flags vec %0d", i), 32'({gearOnA, gearOnB}), 32'(MODE_VEC[i][1:0]));
      step();
    end

    // R2 combinations of pin and register bit
    oeN = '0; regEn = 12'hFFF; step();
    chk("R2 all enabled", 32'(driveEn), 32'hFFF);
    regEn = 12'hAAA; step();
    chk("R2 register bits gate", 32'(driveEn), 32'hAAA);
    regEn = 12'hFFF; oeN[3] = 1'b1; step();
    chk("R2 pin 3 high", 32'(driveEn), 32'hFF7);

    // R3 shared pin for outputs 10 and 11
    oeN = '0; oeN[10] = 1'b1; step();
    chk("R3 shared pin high", 32'(driveEn), 32'h3FF);
    oeN = '0; regEn[11] = 1'b0; step();
    chk("R3 separate register bit", 32'(driveEn), 32'h7FF);

    // R10 change held while output clock is high
    regEn = 12'hFFF; step();
    outPhase = 12'h008; regEn = 12'hFE7; step();
    chk("R10 output 4 applied, 3 held", 32'(driveEn), 32'hFEF);
    step();
    chk("R10 still held while high", 32'(driveEn), 32'hFEF);
    outPhase = '0; step();
    chk("R10 applied once low", 32'(driveEn), 32'hFE7);

    // R7 strap capture
    fsStrap = 1; pwrGdN = 0; step();
    chk("R7 capture while qualified", 32'(fsLatched), 32'h1);
    pwrGdN = 1; fsStrap = 0; step();
    chk("R7 hold when not qualified", 32'(fsLatched), 32'h1);
    pwrGdN = 0; step();
    chk("R7 capture zero", 32'(fsLatched), 32'h0);
    pwrGdN = 1;

    // R8 R9 power-down with hold-off of 3
    regEn = 12'hFFF; step();
    #1 pdReq = 1;
    #0.5;
    chk("R8 async off", 32'(driveEn), 32'h0);
    step(); pdReq = 0;
    step();
    chk("R9 off after edge 1", 32'(driveEn), 32'h0);
    repeat (3) step();
    chk("R9 off after edge 4", 32'(driveEn), 32'h0);
    step();
    chk("R9 on at edge 5", 32'(driveEn), 32'hFFF);

    // R9 zero hold-off
    wakeCount = 8'd0;
    #1 pdReq = 1;
    step(); pdReq = 0;
    step();
    chk("R9 zero count off after edge 1", 32'(driveEn), 32'h0);
    step();
    chk("R9 zero count on at edge 2", 32'(driveEn), 32'hFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule